// File: doc/BRIEF.md
# Crossbar Slave Port Arbiter

This block decides which master of a multi-master crossbar owns one slave port on each clock cycle. Each master presents a 2-bit transfer kind, and every kind other than IDLE counts as a request. The block returns a registered one-hot grant, a combinational flag that tells the slave side to see an IDLE cycle, and a registered flag that marks a grant given by parking and not by arbitration.

A per-port input selects the arbitration scheme, either fixed priority or round robin. When nobody requests, the grant parks on a configurable master, so that master can start with no arbitration cycle. A low-power option parks on no master instead. Each master also has a 3-bit burst slicing setting. This setting cuts undefined-length bursts into fixed-length pieces, and a competing master may take the port at the end of each piece. A new setting is staged and only becomes active when its master issues an IDLE cycle.

Top module: `xbarSlaveArb`

## Requirements
- R1: `grant` is always one-hot or all zero. After a synchronous reset it equals the park master (all zero in low-power park), `parkedGrant` is 1, and the round-robin pointer rests on the last master.
- R2: Transfer kinds are 0 IDLE, 1 SINGLE, 2 BURST_START, 3 BURST_CONT. `forceIdle` is 0 only when the granted master presents a kind other than IDLE. IDLE cycles from masters and cycles with no request never reach the slave bus.
- R3: After a cycle with no request and low-power park off, `grant` selects `parkIdx` and `parkedGrant` is 1. If the parked master then requests, its beat is accepted in that same cycle.
- R4: After a cycle with no request and `lowPowerPark` set, `grant` is all zero.
- R5: With `rrEnable` at 0, arbitration grants the requester with the lowest 3-bit priority. Master i's priority is `prioCfg[3i+2:3i]`. On a tie the lower index wins.
- R6: With `rrEnable` at 1, arbitration searches upward, with wrap-around, from the master after the one most recently granted by arbitration.
- R7: Changes on `parkIdx`, `lowPowerPark`, `rrEnable` and `prioCfg` act on the grant of the very next cycle.
- R8: An owner keeps the port through its burst beats until it issues IDLE, issues a SINGLE, or completes a burst piece. Arbitration then runs, so a lone requester keeps the grant with no gap.
- R9: Burst setting s (3 bits) value 0 never slices a burst. Values 1..7 end a piece every 2^s beats. BURST_START counts as beat 1, each accepted BURST_CONT adds one, and the count survives lost grants.
- R10: A write on `burstCfgWr[i]` stages `burstCfgVal[3i+2:3i]`. The staged value becomes active at the next cycle in which master i presents IDLE. Reset makes every active setting 0 and clears any staged value.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| xferType | input | 2*NUM_MST | Transfer kind per master, master 0 in the low bits |
| burstCfgWr | input | NUM_MST | Per-master strobe that stages a new burst setting |
| burstCfgVal | input | 3*NUM_MST | Burst setting values per master |
| prioCfg | input | 3*NUM_MST | Fixed priority per master, lower is stronger |
| rrEnable | input | 1 | 1 selects round robin, 0 fixed priority |
| parkIdx | input | IDX_W | Master to park on while idle |
| lowPowerPark | input | 1 | Park on no master while idle |
| grant | output | NUM_MST | One-hot owner of the slave port |
| forceIdle | output | 1 | Slave bus must see IDLE this cycle |
| parkedGrant | output | 1 | Current grant came from parking |

## Verification
The properties assume `parkIdx` names an existing master, and the park property only fires under that condition. They also assume transfer kinds are sampled only at clock edges. The stimulus drives every input just after the falling edge and keeps `parkIdx` below NUM_MST. A master that has lost the port keeps presenting its pending kind, so the bench sees competing requests at piece boundaries. It also writes burst settings both inside bursts and during IDLE cycles, so both the staged and the applied paths of the setting are exercised.

// File: rtl/xbarArbPkg.sv
package xbarArbPkg;

  typedef enum logic [1:0] {
    XFER_IDLE   = 2'd0,
    XFER_SINGLE = 2'd1,
    XFER_BSTART = 2'd2,
    XFER_BCONT  = 2'd3
  } xferKindT;

  // strobes from control to the burst datapath, one accepted beat per cycle
  typedef struct packed {
    logic accept;
    logic burstStart;
    logic burstCont;
  } beatStrobeT;

endpackage

// File: rtl/xbarBurstPath.sv
module xbarBurstPath
  import xbarArbPkg::*;
#(
  parameter int NUM_MST = 4,
  parameter int AP_W    = 3,
  localparam int IDX_W  = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [2*NUM_MST-1:0]      xferType,
  input  logic [NUM_MST-1:0]        burstCfgWr,
  input  logic [AP_W*NUM_MST-1:0]   burstCfgVal,
  input  beatStrobeT                strobe,
  input  logic [IDX_W-1:0]          ownerIdx,
  output logic                      apHit
);

  localparam int CNT_W = 2 ** AP_W;

  logic [AP_W*NUM_MST-1:0]  activeFlat;
  logic [CNT_W*NUM_MST-1:0] cntFlat;

  for (genvar g = 0; g < NUM_MST; g++) begin : g_mst
    logic [AP_W-1:0]  activeQ;
    logic [AP_W-1:0]  pendQ;
    logic             pendFlagQ;
    logic [CNT_W-1:0] cntQ;
    logic             isIdle;
    logic             mine;

    assign isIdle = (xferType[2*g +: 2] == XFER_IDLE);
    assign mine   = strobe.accept && (ownerIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        activeQ   <= '0;
        pendQ     <= '0;
        pendFlagQ <= 1'b0;
        cntQ      <= '0;
      end else begin
        if (isIdle && pendFlagQ) activeQ <= pendQ;
        if (burstCfgWr[g]) begin
          pendQ     <= burstCfgVal[AP_W*g +: AP_W];
          pendFlagQ <= 1'b1;
        end else if (isIdle) begin
          pendFlagQ <= 1'b0;
        end
        if (mine) begin
          if (strobe.burstStart)     cntQ <= CNT_W'(1);
          else if (strobe.burstCont) cntQ <= cntQ + CNT_W'(1);
          else                       cntQ <= '0;
        end
      end
    end

    assign activeFlat[AP_W*g +: AP_W]  = activeQ;
    assign cntFlat[CNT_W*g +: CNT_W]   = cntQ;
  end

  logic [AP_W-1:0]  selSet;
  logic [CNT_W-1:0] selCnt;
  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W-1:0] pieceMask;

  always_comb begin
    selSet    = activeFlat[AP_W*ownerIdx +: AP_W];
    selCnt    = cntFlat[CNT_W*ownerIdx +: CNT_W];
    nextCnt   = strobe.burstStart ? CNT_W'(1) : selCnt + CNT_W'(1);
    pieceMask = (CNT_W'(1) << selSet) - CNT_W'(1);
    apHit     = (strobe.burstStart || strobe.burstCont) && (selSet != '0)
                && ((nextCnt & pieceMask) == '0);
  end

endmodule

// File: rtl/xbarArbCtrl.sv
module xbarArbCtrl
  import xbarArbPkg::*;
#(
  parameter int NUM_MST = 4,
  parameter int PRI_W   = 3,
  localparam int IDX_W  = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [2*NUM_MST-1:0]     xferType,
  input  logic [PRI_W*NUM_MST-1:0] prioCfg,
  input  logic                     rrEnable,
  input  logic [IDX_W-1:0]         parkIdx,
  input  logic                     lowPowerPark,
  input  logic                     apHit,
  output logic [NUM_MST-1:0]       grant,
  output logic                     parkedGrant,
  output logic                     forceIdle,
  output beatStrobeT               strobe,
  output logic [IDX_W-1:0]         ownerIdx
);

  logic [NUM_MST-1:0] grantQ, grantD, reqVec, parkVec;
  logic               parkedQ, parkedD;
  logic [IDX_W-1:0]   rrPtrQ, rrPtrD;
  logic [IDX_W-1:0]   fixWin, rrWin, win;
  logic [PRI_W-1:0]   bestPri;
  logic               fixFound, rrFound, ownerReq, hold;
  xferKindT           ownerXfer;
  int                 probe;

  always_comb begin
    for (int i = 0; i < NUM_MST; i++) reqVec[i] = (xferType[2*i +: 2] != XFER_IDLE);
  end

  always_comb begin
    ownerIdx = '0;
    for (int i = 0; i < NUM_MST; i++) if (grantQ[i]) ownerIdx = IDX_W'(i);
  end

  always_comb begin
    ownerXfer         = xferKindT'(xferType[2*ownerIdx +: 2]);
    ownerReq          = |(grantQ & reqVec);
    strobe.accept     = ownerReq;
    strobe.burstStart = ownerReq && (ownerXfer == XFER_BSTART);
    strobe.burstCont  = ownerReq && (ownerXfer == XFER_BCONT);
    hold              = (strobe.burstStart || strobe.burstCont) && !apHit;
  end

  // fixed priority: lowest value, lower index on ties
  always_comb begin
    fixWin   = '0;
    bestPri  = '1;
    fixFound = 1'b0;
    for (int i = 0; i < NUM_MST; i++) begin
      if (reqVec[i] && (!fixFound || prioCfg[PRI_W*i +: PRI_W] < bestPri)) begin
        fixFound = 1'b1;
        bestPri  = prioCfg[PRI_W*i +: PRI_W];
        fixWin   = IDX_W'(i);
      end
    end
  end

  // round robin: first requester after the pointer
  always_comb begin
    rrWin   = '0;
    rrFound = 1'b0;
    probe   = 0;
    for (int k = 1; k <= NUM_MST; k++) begin
      probe = (int'(rrPtrQ) + k) % NUM_MST;
      if (!rrFound && reqVec[probe]) begin
        rrFound = 1'b1;
        rrWin   = IDX_W'(probe);
      end
    end
  end

  always_comb begin
    win = rrEnable ? rrWin : fixWin;
    if (lowPowerPark || int'(parkIdx) >= NUM_MST) parkVec = '0;
    else                                          parkVec = NUM_MST'(1) << parkIdx;
  end

  always_comb begin
    grantD  = grantQ;
    parkedD = parkedQ;
    rrPtrD  = rrPtrQ;
    if (hold) begin
      parkedD = 1'b0;
    end else if (|reqVec) begin
      grantD  = NUM_MST'(1) << win;
      parkedD = 1'b0;
      rrPtrD  = win;
    end else begin
      grantD  = parkVec;
      parkedD = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ  <= parkVec;
      parkedQ <= 1'b1;
      rrPtrQ  <= IDX_W'(NUM_MST - 1);
    end else begin
      grantQ  <= grantD;
      parkedQ <= parkedD;
      rrPtrQ  <= rrPtrD;
    end
  end

  assign grant       = grantQ;
  assign parkedGrant = parkedQ;
  assign forceIdle   = !ownerReq;

endmodule

// File: rtl/xbarSlaveArb.sv
module xbarSlaveArb
  import xbarArbPkg::*;
#(
  parameter int NUM_MST = 4,
  parameter int PRI_W   = 3,
  parameter int AP_W    = 3,
  localparam int IDX_W  = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [2*NUM_MST-1:0]     xferType,
  input  logic [NUM_MST-1:0]       burstCfgWr,
  input  logic [AP_W*NUM_MST-1:0]  burstCfgVal,
  input  logic [PRI_W*NUM_MST-1:0] prioCfg,
  input  logic                     rrEnable,
  input  logic [IDX_W-1:0]         parkIdx,
  input  logic                     lowPowerPark,
  output logic [NUM_MST-1:0]       grant,
  output logic                     forceIdle,
  output logic                     parkedGrant
);

  beatStrobeT       strobe;
  logic [IDX_W-1:0] ownerIdx;
  logic             apHit;

  xbarArbCtrl #(.NUM_MST(NUM_MST), .PRI_W(PRI_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .xferType(xferType), .prioCfg(prioCfg),
    .rrEnable(rrEnable), .parkIdx(parkIdx), .lowPowerPark(lowPowerPark),
    .apHit(apHit), .grant(grant), .parkedGrant(parkedGrant),
    .forceIdle(forceIdle), .strobe(strobe), .ownerIdx(ownerIdx)
  );

  xbarBurstPath #(.NUM_MST(NUM_MST), .AP_W(AP_W)) u_burst (
    .clk(clk), .rstN(rstN), .xferType(xferType), .burstCfgWr(burstCfgWr),
    .burstCfgVal(burstCfgVal), .strobe(strobe), .ownerIdx(ownerIdx),
    .apHit(apHit)
  );

endmodule

// File: rtl/xbarSlaveArbChk.sv
module xbarSlaveArbChk #(
  parameter int NUM_MST = 4,
  parameter int IDX_W   = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [2*NUM_MST-1:0] xferType,
  input logic [IDX_W-1:0]     parkIdx,
  input logic                 lowPowerPark,
  input logic [NUM_MST-1:0]   grant,
  input logic                 forceIdle,
  input logic                 parkedGrant
);

  logic [NUM_MST-1:0] reqVec;
  always_comb begin
    for (int i = 0; i < NUM_MST; i++) reqVec[i] = (xferType[2*i +: 2] != 2'd0);
  end

  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  assert_no_request_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqVec == '0) |-> forceIdle);

  assert_park_on_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!lowPowerPark && reqVec == '0 && int'(parkIdx) < NUM_MST)
      |=> (grant == (NUM_MST'(1) << $past(parkIdx))) && parkedGrant);

  assert_lowpower_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lowPowerPark && reqVec == '0) |=> (grant == '0));

  assert_lone_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (grant != '0 && reqVec == grant) |=> (grant == $past(grant)));

  assert_handover_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((grant & reqVec) == '0 && reqVec != '0) |=> ((grant & $past(reqVec)) != '0));

endmodule

bind xbarSlaveArb xbarSlaveArbChk #(.NUM_MST(NUM_MST), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .xferType(xferType), .parkIdx(parkIdx),
  .lowPowerPark(lowPowerPark), .grant(grant), .forceIdle(forceIdle),
  .parkedGrant(parkedGrant)
);

// File: tb/xbarSlaveArb_tb.sv
module xbarSlaveArb_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN;
  logic [2*N-1:0] xferType;
  logic [N-1:0]   burstCfgWr;
  logic [3*N-1:0] burstCfgVal;
  logic [3*N-1:0] prioCfg;
  logic           rrEnable;
  logic [1:0]     parkIdx;
  logic           lowPowerPark;
  logic [N-1:0]   grant;
  logic           forceIdle;
  logic           parkedGrant;

  always #5 clk = ~clk;

  xbarSlaveArb u_dut (
    .clk(clk), .rstN(rstN), .xferType(xferType), .burstCfgWr(burstCfgWr),
    .burstCfgVal(burstCfgVal), .prioCfg(prioCfg), .rrEnable(rrEnable),
    .parkIdx(parkIdx), .lowPowerPark(lowPowerPark), .grant(grant),
    .forceIdle(forceIdle), .parkedGrant(parkedGrant)
  );

  // reference model state
  int owner, rrLast;
  int actSet[N], pendSet[N], cnt[N];
  bit pendFlag[N];
  bit parkedM;
  int nCmp = 0, nBad = 0;
  bit done = 0;
  string tag = "R1";

  function automatic int kindOf(int m);
    return int'(xferType[2*m +: 2]);
  endfunction

  function automatic int parkTarget();
    return lowPowerPark ? -1 : int'(parkIdx);
  endfunction

  function automatic logic [7:0] xf4(int a, int b, int c, int d);
    return {d[1:0], c[1:0], b[1:0], a[1:0]};
  endfunction

  task automatic checkOne(string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    int expG = (owner >= 0) ? (1 << owner) : 0;
    int expFi = (owner >= 0 && kindOf(owner) != 0) ? 0 : 1;
    checkOne("grant", int'(grant), expG);
    checkOne("forceIdle", int'(forceIdle), expFi);
    checkOne("parkedGrant", int'(parkedGrant), int'(parkedM));
  endtask

  task automatic modelStep();
    bit hold = 0;
    bit anyReq = 0;
    int win = -1;
    if (owner >= 0 && kindOf(owner) != 0) begin
      int k = kindOf(owner);
      if (k >= 2) begin
        int nc = (k == 2) ? 1 : cnt[owner] + 1;
        bit ap = (actSet[owner] != 0) && ((nc % (1 << actSet[owner])) == 0);
        hold = !ap;
        cnt[owner] = nc % 256;
      end else cnt[owner] = 0;
    end
    for (int m = 0; m < N; m++) begin
      bit idle = (kindOf(m) == 0);
      if (idle && pendFlag[m]) actSet[m] = pendSet[m];
      if (burstCfgWr[m]) begin
        pendSet[m] = int'(burstCfgVal[3*m +: 3]);
        pendFlag[m] = 1;
      end else if (idle) pendFlag[m] = 0;
      if (kindOf(m) != 0) anyReq = 1;
    end
    if (hold) parkedM = 0;
    else if (anyReq) begin
      if (rrEnable) begin
        for (int k = 1; k <= N; k++)
          if (win < 0 && kindOf((rrLast + k) % N) != 0) win = (rrLast + k) % N;
      end else begin
        int best = 99;
        for (int m = 0; m < N; m++) begin
          int p = int'(prioCfg[3*m +: 3]);
          if (kindOf(m) != 0 && p < best) begin best = p; win = m; end
        end
      end
      owner = win; rrLast = win; parkedM = 0;
    end else begin
      owner = parkTarget(); parkedM = 1;
    end
  endtask

  task automatic cyc(logic [2*N-1:0] xf, logic [N-1:0] wr = '0);
    xferType = xf;
    burstCfgWr = wr;
    #1;
    compareAll();
    modelStep();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    rstN = 0; xferType = '0; burstCfgWr = '0; burstCfgVal = '0;
    prioCfg = {3'd7, 3'd1, 3'd1, 3'd5}; rrEnable = 0; parkIdx = 2; lowPowerPark = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    owner = 2; rrLast = N - 1; parkedM = 1;
    for (int m = 0; m < N; m++) begin actSet[m] = 0; pendSet[m] = 0; cnt[m] = 0; pendFlag[m] = 0; end

    tag = "R1";  cyc(xf4(0,0,0,0));
    tag = "R2";  cyc(xf4(0,0,0,0)); cyc(xf4(0,0,0,0));
    tag = "R3";  cyc(xf4(0,0,1,0)); cyc(xf4(0,0,0,0));
    tag = "R2";  cyc(xf4(0,1,0,0)); cyc(xf4(0,0,0,0));
    // fixed priority: master 1 and 2 tie at 1, 1 wins, singles re-arbitrate
    tag = "R5";
    for (int i = 0; i < 4; i++) cyc(xf4(1,1,1,1));
    cyc(xf4(1,0,1,1)); cyc(xf4(1,0,0,1)); cyc(xf4(0,0,0,1));
    tag = "R7"; prioCfg = {3'd0, 3'd6, 3'd6, 3'd6};
    cyc(xf4(1,1,1,1)); cyc(xf4(1,1,1,1));
    parkIdx = 0; cyc(xf4(0,0,0,0)); cyc(xf4(0,0,0,0));
    // round robin rotation
    tag = "R6"; rrEnable = 1;
    for (int i = 0; i < 9; i++) cyc(xf4(1,1,1,1));
    cyc(xf4(1,0,1,0)); cyc(xf4(1,0,1,0)); cyc(xf4(1,0,1,0));
    // low power park
    tag = "R4"; lowPowerPark = 1;
    cyc(xf4(0,0,0,0)); cyc(xf4(0,0,0,0)); cyc(xf4(0,1,0,0)); cyc(xf4(0,0,0,0));
    tag = "R7"; lowPowerPark = 0; parkIdx = 3;
    cyc(xf4(0,0,0,0)); cyc(xf4(0,0,0,0));
    // setting 0: owner keeps through a burst although others request
    tag = "R8";
    cyc(xf4(2,0,0,0));
    for (int i = 0; i < 6; i++) cyc(xf4(3,2,0,0));
    cyc(xf4(0,2,0,0)); cyc(xf4(0,3,0,0)); cyc(xf4(0,3,0,0)); cyc(xf4(0,0,0,0));
    // stage setting 1 for masters 0 and 1, applied on idle
    tag = "R10"; burstCfgVal = {3'd0, 3'd0, 3'd1, 3'd1};
    cyc(xf4(0,0,0,0), 4'b0011); cyc(xf4(0,0,0,0));
    // 2-beat pieces alternate between 0 and 1
    tag = "R9";
    cyc(xf4(2,2,0,0));
    for (int i = 0; i < 10; i++) cyc(xf4(3,3,0,0));
    tag = "R8";
    for (int i = 0; i < 5; i++) cyc(xf4(3,0,0,0));
    cyc(xf4(0,0,0,0));
    // write during burst of master 2 stays staged
    tag = "R10"; burstCfgVal = {3'd0, 3'd2, 3'd0, 3'd0};
    cyc(xf4(0,0,2,0));
    cyc(xf4(0,0,3,2), 4'b0100);
    for (int i = 0; i < 6; i++) cyc(xf4(0,0,3,3));
    cyc(xf4(0,0,0,3)); cyc(xf4(0,0,0,3)); cyc(xf4(0,0,0,0));
    tag = "R9";
    cyc(xf4(0,0,2,2));
    for (int i = 0; i < 12; i++) cyc(xf4(0,0,3,3));
    cyc(xf4(0,0,0,0));
    // reset mid-burst clears staged and active settings
    tag = "R1"; burstCfgVal = {3'd1, 3'd1, 3'd1, 3'd1};
    cyc(xf4(2,0,0,0), 4'b1111);
    rstN = 0; xferType = '0; burstCfgWr = '0;
    @(posedge clk); @(negedge clk);
    rstN = 1; owner = 3; rrLast = N - 1; parkedM = 1;
    for (int m = 0; m < N; m++) begin actSet[m] = 0; pendSet[m] = 0; cnt[m] = 0; pendFlag[m] = 0; end
    cyc(xf4(0,0,0,0));
    tag = "R10";
    cyc(xf4(2,2,0,0));
    for (int i = 0; i < 5; i++) cyc(xf4(3,3,0,0));
    cyc(xf4(0,0,0,0));
    finishRun();
  end
endmodule